// File: doc/BRIEF.md
# Quarter-Duty LCD Waveform Sequencer

This block drives a multiplexed LCD panel with four common lines and twenty-four segment lines. The panel image comes from a 96-bit display memory that a host loads. The block does not make analog voltages. Each pin receives a 3-bit level code, and an external analog stage turns that code into a voltage. A free-running timebase selects each common in turn. Every common's time slot is split into two halves of opposite polarity, so the panel sees no net DC drive.

Run-time controls set the rest of the behaviour. One bit chooses between the half-bias and third-bias schemes. A blank bit replaces every segment pattern with the off-waveform. A sleep bit pulls the display outputs low. Two further fields give the shared pins their function. Up to four of the lowest segment pins can be general-purpose outputs with static levels. The two highest segment pins can be handed over to an external key scanner.

Top module: `lcdq_wave_seq`

## Requirements
- R1: One frame is 8·HALF_LEN clocks (512 by default). Common c is selected for counts 128c to 128c+127 after reset or sleep release, and the first half of each slot is phase A. Outputs are registered, so the output in the clock after count k reflects count k. The pattern repeats every frame.
- R2: Level codes are 0 ground, 1 one-third, 2 two-thirds, 3 full, 4 half and 5 key-scan handover. With half_bias=0, a selected common drives 3 in phase A and 0 in phase B. A non-selected common drives 1 in phase A and 2 in phase B.
- R3: With half_bias=1, a selected common drives 3 then 0, and a non-selected common drives 4 in both phases.
- R4: Segment pin n reads disp_data bit 4n+c while common c is selected. A 1 means on, and an on segment drives 0 in phase A and 3 in phase B under either bias.
- R5: An off segment drives 2 then 1 under third bias, and 3 then 0 under half bias.
- R6: blank=1 makes every pin in segment function drive the off-waveform. The commons keep running unchanged.
- R7: sleep=1 drives all commons and all segment-function pins to 0 and holds the timebase at count 0. After release, the timebase restarts at count 0.
- R8: Pin i, where i is below min(gpo_sel,4), is a general-purpose output. It drives 3 when disp_data bit 4i is 1 and 0 otherwise, whatever the phase, blank or sleep state.
- R9: key_mode 0 hands pins 22 and 23 to the key scanner (code 5). key_mode 1 hands over pin 23 only. key_mode 2 or 3 keeps both pins as segments.
- R10: While rst is high, every output is 0. This forces every pin to segment function, low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_data | input | 96 | Display memory, bit 4n+c for segment n and common c |
| half_bias | input | 1 | 1 selects half bias, 0 selects third bias |
| blank | input | 1 | Forces segment off-waveforms |
| sleep | input | 1 | Low-power state with the display held low |
| gpo_sel | input | 3 | Number of low pins used as general-purpose outputs (values above 4 count as 4) |
| key_mode | input | 2 | Hands the top segment pins to the key scanner |
| com_lvl | output | 12 | Level code for each common, 3 bits each |
| seg_lvl | output | 72 | Level code for each segment pin, 3 bits each |

## Verification
The hardest cases to reach are the late slots of a frame, such as common 3 in phase B at count 511, and the return to count 0 after sleep. Both can only be observed after hundreds of clocks. The stimulus table therefore restarts the block from reset for each vector and counts clocks to the exact target count. The sleep restart is reached by holding sleep for a while and then releasing it on a known edge. The bench then confirms that the first output is the frame start and that phase B follows exactly 64 clocks later.

// File: rtl/lcdq_pkg.sv
package lcdq_pkg;
  localparam int LVW = 3;
  typedef enum logic [LVW-1:0] {
    LV_ZERO  = 3'd0,
    LV_THIRD = 3'd1,
    LV_TWOTH = 3'd2,
    LV_FULL  = 3'd3,
    LV_HALF  = 3'd4,
    LV_KEY   = 3'd5
  } lvl_e;
endpackage

// File: rtl/lcdq_timebase.sv
module lcdq_timebase #(
  parameter int HALF_LEN = 64,
  parameter int NCOM     = 4,
  localparam int HW  = $clog2(HALF_LEN),
  localparam int CSW = $clog2(NCOM),
  localparam int CW  = HW + 1 + CSW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold,
  output logic [CSW-1:0] com_sel,
  output logic           phase_b
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign com_sel = cnt[CW-1 -: CSW];
  assign phase_b = cnt[HW];
endmodule

// File: rtl/lcdq_com_drv.sv
module lcdq_com_drv
  import lcdq_pkg::*;
#(
  parameter int NCOM = 4,
  localparam int CSW = $clog2(NCOM)
) (
  input  logic [CSW-1:0]      com_sel,
  input  logic                phase_b,
  input  logic                half_bias,
  input  logic                sleep,
  output logic [NCOM*LVW-1:0] com_nxt
);
  for (genvar c = 0; c < NCOM; c++) begin : g_com
    lvl_e lv;
    always_comb begin
      if (sleep)                 lv = LV_ZERO;
      else if (com_sel == CSW'(c)) lv = phase_b ? LV_ZERO : LV_FULL;
      else if (half_bias)        lv = LV_HALF;
      else                       lv = phase_b ? LV_TWOTH : LV_THIRD;
    end
    assign com_nxt[c*LVW +: LVW] = lv;
  end
endmodule

// File: rtl/lcdq_seg_cell.sv
module lcdq_seg_cell
  import lcdq_pkg::*;
#(
  parameter int PIN  = 0,
  parameter int NCOM = 4,
  parameter int NSEG = 24,
  parameter int NGPO = 4,
  localparam int CSW = $clog2(NCOM),
  localparam bit GPO_OK  = (PIN < NGPO),
  localparam bit KEY_LO  = (PIN == NSEG - 2),
  localparam bit KEY_HI  = (PIN == NSEG - 1)
) (
  input  logic [NCOM-1:0] nib,
  input  logic [CSW-1:0]  com_sel,
  input  logic            phase_b,
  input  logic            half_bias,
  input  logic            blank,
  input  logic            sleep,
  input  logic [2:0]      gpo_cnt,
  input  logic [1:0]      key_mode,
  output logic [LVW-1:0]  lvl
);
  logic is_gpo, is_key, seg_on;
  lvl_e lv;

  assign is_gpo = GPO_OK && (int'(gpo_cnt) > PIN);
  assign is_key = (KEY_LO && key_mode == 2'd0) || (KEY_HI && key_mode <= 2'd1);
  assign seg_on = nib[com_sel] && !blank;

  always_comb begin
    if (is_gpo)         lv = nib[0] ? LV_FULL : LV_ZERO;
    else if (is_key)    lv = LV_KEY;
    else if (sleep)     lv = LV_ZERO;
    else if (seg_on)    lv = phase_b ? LV_FULL : LV_ZERO;
    else if (half_bias) lv = phase_b ? LV_ZERO : LV_FULL;
    else                lv = phase_b ? LV_THIRD : LV_TWOTH;
  end

  assign lvl = lv;
endmodule

// File: rtl/lcdq_wave_seq.sv
module lcdq_wave_seq
  import lcdq_pkg::*;
#(
  parameter int HALF_LEN = 64,
  parameter int NCOM     = 4,
  parameter int NSEG     = 24,
  parameter int NGPO     = 4,
  localparam int CSW = $clog2(NCOM)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSEG*NCOM-1:0]   disp_data,
  input  logic                   half_bias,
  input  logic                   blank,
  input  logic                   sleep,
  input  logic [2:0]             gpo_sel,
  input  logic [1:0]             key_mode,
  output logic [NCOM*LVW-1:0]    com_lvl,
  output logic [NSEG*LVW-1:0]    seg_lvl
);
  logic [CSW-1:0]       com_sel;
  logic                 phase_b;
  logic [2:0]           gpo_cnt;
  logic [NCOM*LVW-1:0]  com_nxt;
  logic [NSEG*LVW-1:0]  seg_nxt;

  assign gpo_cnt = (gpo_sel > 3'(NGPO)) ? 3'(NGPO) : gpo_sel;

  lcdq_timebase #(.HALF_LEN(HALF_LEN), .NCOM(NCOM)) u_tb (
    .clk(clk), .rst(rst), .hold(sleep), .com_sel(com_sel), .phase_b(phase_b)
  );

  lcdq_com_drv #(.NCOM(NCOM)) u_com (
    .com_sel(com_sel), .phase_b(phase_b), .half_bias(half_bias),
    .sleep(sleep), .com_nxt(com_nxt)
  );

  for (genvar n = 0; n < NSEG; n++) begin : g_seg
    lcdq_seg_cell #(.PIN(n), .NCOM(NCOM), .NSEG(NSEG), .NGPO(NGPO)) u_cell (
      .nib(disp_data[n*NCOM +: NCOM]), .com_sel(com_sel), .phase_b(phase_b),
      .half_bias(half_bias), .blank(blank), .sleep(sleep),
      .gpo_cnt(gpo_cnt), .key_mode(key_mode), .lvl(seg_nxt[n*LVW +: LVW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      com_lvl <= '0;
      seg_lvl <= '0;
    end else begin
      com_lvl <= com_nxt;
      seg_lvl <= seg_nxt;
    end
  end
endmodule

// File: rtl/lcdq_wave_seq_chk.sv
module lcdq_wave_seq_chk #(
  parameter int NCOM = 4,
  parameter int NSEG = 24
) (
  input logic                clk,
  input logic                rst,
  input logic                half_bias,
  input logic                blank,
  input logic                sleep,
  input logic [2:0]          gpo_sel,
  input logic [1:0]          key_mode,
  input logic                d0,
  input logic [NCOM*3-1:0]   com_lvl,
  input logic [NSEG*3-1:0]   seg_lvl
);
  logic [NCOM-1:0] sel_v, thirds_v;
  logic [2:0]      top_lv;

  always_comb begin
    for (int c = 0; c < NCOM; c++) begin
      sel_v[c]    = (com_lvl[c*3 +: 3] == 3'd3) || (com_lvl[c*3 +: 3] == 3'd0);
      thirds_v[c] = (com_lvl[c*3 +: 3] == 3'd1) || (com_lvl[c*3 +: 3] == 3'd2);
    end
  end
  assign top_lv = seg_lvl[(NSEG-1)*3 +: 3];

  // R10: reset drives everything low
  a_r10_reset_zero: assert property (@(posedge clk)
    rst |=> (com_lvl == '0 && seg_lvl == '0));
  // R7: sleep holds commons low
  a_r7_sleep_com_low: assert property (@(posedge clk) disable iff (rst)
    sleep |=> com_lvl == '0);
  // R1: exactly one common selected while awake
  a_r1_one_selected: assert property (@(posedge clk) disable iff (rst)
    !sleep |=> $onehot(sel_v));
  // R3: half bias never uses third levels on commons
  a_r3_half_no_thirds: assert property (@(posedge clk) disable iff (rst)
    (half_bias && !sleep) |=> thirds_v == '0);
  // R9: key mode 0 hands both top pins over
  a_r9_key_pins: assert property (@(posedge clk) disable iff (rst)
    key_mode == 2'd0 |=> (seg_lvl[(NSEG-2)*3 +: 3] == 3'd5 && top_lv == 3'd5));
  // R8: first pin as static output
  a_r8_gpo_first: assert property (@(posedge clk) disable iff (rst)
    gpo_sel != 3'd0 |=> seg_lvl[2:0] == ($past(d0) ? 3'd3 : 3'd0));
  // R6: blank gives off-waveform under third bias
  a_r6_blank_off: assert property (@(posedge clk) disable iff (rst)
    (blank && !sleep && !half_bias && key_mode[1]) |=> (top_lv == 3'd1 || top_lv == 3'd2));
endmodule

bind lcdq_wave_seq lcdq_wave_seq_chk #(.NCOM(NCOM), .NSEG(NSEG)) u_chk (
  .clk(clk), .rst(rst), .half_bias(half_bias), .blank(blank), .sleep(sleep),
  .gpo_sel(gpo_sel), .key_mode(key_mode), .d0(disp_data[0]),
  .com_lvl(com_lvl), .seg_lvl(seg_lvl)
);

// File: tb/lcdq_wave_seq_tb.sv
`timescale 1ns/1ps
module lcdq_wave_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [95:0] disp_data = '0;
  logic        half_bias = 1'b0, blank = 1'b0, sleep = 1'b0;
  logic [2:0]  gpo_sel = 3'd0;
  logic [1:0]  key_mode = 2'd2;
  logic [11:0] com_lvl;
  logic [71:0] seg_lvl;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lcdq_wave_seq u_dut (
    .clk(clk), .rst(rst), .disp_data(disp_data), .half_bias(half_bias),
    .blank(blank), .sleep(sleep), .gpo_sel(gpo_sel), .key_mode(key_mode),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // {half_bias, blank, nib of seg 5, count, expected com0, expected seg5}
  localparam logic [20:0] VEC [12] = '{
    {1'b0, 1'b0, 4'b0001, 9'd0,   3'd3, 3'd0},
    {1'b0, 1'b0, 4'b0001, 9'd64,  3'd0, 3'd3},
    {1'b0, 1'b0, 4'b0001, 9'd128, 3'd1, 3'd2},
    {1'b0, 1'b0, 4'b0001, 9'd192, 3'd2, 3'd1},
    {1'b1, 1'b0, 4'b0010, 9'd130, 3'd4, 3'd0},
    {1'b1, 1'b0, 4'b0010, 9'd200, 3'd4, 3'd3},
    {1'b1, 1'b0, 4'b0010, 9'd10,  3'd3, 3'd3},
    {1'b1, 1'b0, 4'b0010, 9'd70,  3'd0, 3'd0},
    {1'b0, 1'b1, 4'b1111, 9'd384, 3'd1, 3'd2},
    {1'b0, 1'b1, 4'b1111, 9'd511, 3'd2, 3'd1},
    {1'b1, 1'b1, 4'b1000, 9'd400, 3'd4, 3'd3},
    {1'b0, 1'b0, 4'b1000, 9'd448, 3'd2, 3'd3}
  };

  function automatic logic [2:0] seg_at(int i);
    return seg_lvl[i*3 +: 3];
  endfunction
  function automatic logic [2:0] com_at(int i);
    return com_lvl[i*3 +: 3];
  endfunction

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic run_to(int p);
    repeat (p + 1) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R10: reset state with pins requested as outputs and key pins
    gpo_sel = 3'd4; disp_data[0] = 1'b1; key_mode = 2'd0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R10 com", 3'(com_lvl != '0), 3'd0);
    check("R10 seg", 3'(seg_lvl != '0), 3'd0);

    // R2 R3 R4 R5 R6 R1: table walk
    gpo_sel = 3'd0; key_mode = 2'd2; disp_data = '0;
    for (int v = 0; v < 12; v++) begin
      half_bias = VEC[v][20];
      blank     = VEC[v][19];
      disp_data = '0;
      disp_data[23:20] = VEC[v][18:15];
      do_reset();
      run_to(int'(VEC[v][14:6]));
      check($sformatf("R2/R3 com0 vec%0d", v), com_at(0), VEC[v][5:3]);
      check($sformatf("R4/R5/R6 seg5 vec%0d", v), seg_at(5), VEC[v][2:0]);
    end
    blank = 1'b0; half_bias = 1'b0;

    // R1: slot boundary and frame wrap
    disp_data = '0;
    do_reset(); run_to(127);
    check("R1 com0 end of slot", com_at(0), 3'd0);
    run_to(0);
    check("R1 com1 selected at 128", com_at(1), 3'd3);
    check("R1 com0 released at 128", com_at(0), 3'd1);
    run_to(383);
    check("R1 frame wrap com0", com_at(0), 3'd3);

    // R7 R8 R9: sleep with outputs and key pins
    sleep = 1'b1; gpo_sel = 3'd2; key_mode = 2'd1;
    disp_data = '0; disp_data[0] = 1'b1; disp_data[11:8] = 4'b1111;
    do_reset(); run_to(10);
    check("R8 pin0 in sleep", seg_at(0), 3'd3);
    check("R8 pin1 in sleep", seg_at(1), 3'd0);
    check("R7 pin2 sleep low", seg_at(2), 3'd0);
    check("R7 com0 sleep low", com_at(0), 3'd0);
    check("R9 pin23 key mode1", seg_at(23), 3'd5);
    check("R9 pin22 segment mode1", seg_at(22), 3'd0);
    run_to(100);
    @(negedge clk) sleep = 1'b0;
    run_to(0);
    check("R7 restart at count 0", com_at(0), 3'd3);
    run_to(63);
    check("R7 phase B 64 clocks later", com_at(0), 3'd0);

    // R9: both top pins as segments, then both handed over
    gpo_sel = 3'd0; key_mode = 2'd2; disp_data = '0; disp_data[92] = 1'b1;
    do_reset(); run_to(0);
    check("R9 pin23 segment on", seg_at(23), 3'd0);
    check("R9 pin22 segment off", seg_at(22), 3'd2);
    key_mode = 2'd0;
    do_reset(); run_to(5);
    check("R9 pin22 key", seg_at(22), 3'd5);
    check("R9 pin23 key", seg_at(23), 3'd5);

    // R8 R6: clamp of large select, blank leaves outputs static
    key_mode = 2'd2; blank = 1'b1; gpo_sel = 3'd7;
    disp_data = '0; disp_data[12] = 1'b1; disp_data[19:16] = 4'b1111;
    do_reset(); run_to(70);
    check("R8 pin3 clamp high", seg_at(3), 3'd3);
    check("R6 pin4 blank off", seg_at(4), 3'd1);
    check("R8 pin2 static low", seg_at(2), 3'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule